// File: doc/BRIEF.md
# Tiled Convolution Multiply-Accumulate Engine

This engine computes one output tile of a convolutional layer from on-chip memories that sit beside it. The datapath has `TM` parallel lanes, one per output channel of the current group. Each lane forms a dot product across `TN` input channels in one cycle and adds it to the running sum of its output pixel. One cycle covers one kernel tap of one output pixel for a full `TM`×`TN` channel block. The running sum is read, updated and written back through a read-modify-write port on the output memory.

A run starts with a one-cycle `start` pulse. The engine then steps through the output-channel groups, the input-channel groups, the tile rows, the tile columns and the kernel rows and columns, in that nesting, one step per clock. On the first input-channel group the old accumulator contents are replaced by the channel bias. On the last tap of the last group the result is rectified. The sums are signed fixed point and saturate. When the final write has been committed, `done` pulses once.

Top module: `conv_tile_engine`

## Requirements
- R1: After reset `busy`, `done` and `acc_we` are all 0.
- R2: A run has exactly OG·IG·TR·TC·K·K steps, one per clock, in the order output group (outermost), input group, tile row, tile column, kernel row, kernel column (innermost). The first step is at (0,0,0,0,0,0) in the cycle after `start` is sampled.
- R3: In every step the input read is at group ng, row S·r+i and column S·c+j. The weight read is at (og, ng, i, j) and the accumulator access is at (og, r, c).
- R4: Lane m writes old + Σt w[m][t]·x[t]. Input channel t sits in `in_data[t*DW +: DW]`, weight (m,t) in `wt_data[(m*TN+t)*DW +: DW]`, and lane m in bits `[m*AW +: AW]` of `bias_data`, `acc_rd_data` and `acc_wr_data`. All values are two's complement.
- R5: On a step with ng=0, i=0 and j=0 the old value is the lane's bias from `bias_data`, and `acc_rd_data` is ignored.
- R6: Each written sum saturates to the signed AW-bit range instead of wrapping.
- R7: Only on a step with ng=IG−1, i=K−1 and j=K−1 is a negative result written as 0. All partial sums, including negative ones, are written unclamped.
- R8: `done` is high for exactly one cycle, the cycle after the final write. In that cycle `busy` and `acc_we` are already 0.
- R9: A `start` pulse while a run is in progress has no effect on the sweep.
- R10: `acc_we` is high in every step of a run and low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| in_grp | output | idx(IG) | Input-channel group of the input read |
| in_row | output | idx((TR-1)S+K) | Input tile row |
| in_col | output | idx((TC-1)S+K) | Input tile column |
| in_data | input | TN*DW | TN input samples (asynchronous read) |
| wt_ogrp | output | idx(OG) | Output group of the weight read |
| wt_igrp | output | idx(IG) | Input group of the weight read |
| wt_krow | output | idx(K) | Kernel row |
| wt_kcol | output | idx(K) | Kernel column |
| wt_data | input | TM*TN*DW | Weight block (asynchronous read) |
| bias_grp | output | idx(OG) | Output group of the bias lookup |
| bias_data | input | TM*AW | Biases of the TM lanes |
| acc_grp | output | idx(OG) | Output group of the accumulator access |
| acc_row | output | idx(TR) | Output tile row |
| acc_col | output | idx(TC) | Output tile column |
| acc_rd_data | input | TM*AW | Current accumulator values (asynchronous read) |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wr_data | output | TM*AW | Updated accumulator values |

## Verification
The engine is driven with several data patterns:
- Small random data and biases of both signs. These expose any error in lane packing, window addressing with stride 2, and the split between bias seeding and read-back.
- Full-range random data. This tests sign handling in the products.
- All-maximum data with a near-maximum bias. This forces positive saturation.
- Maximum inputs against most-negative weights. This drives the sums to negative saturation, shows that negative partial sums are stored unclamped, and checks that only the final step rectifies.
- A large negative bias with small positive data. This shows the rectifier at work.

The old accumulator memory is filled with junk before every run, so a missed bias seed shows up in the results. A stray `start` in the middle of a run and a back-to-back restart check the handshake.

// File: rtl/conv_tile_pkg.sv
package conv_tile_pkg;
    // Index width for a range of n values (never below one bit)
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/conv_tile_sweep.sv
module conv_tile_sweep
    import conv_tile_pkg::*;
#(
    parameter int OG = 2,
    parameter int IG = 2,
    parameter int TR = 3,
    parameter int TC = 3,
    parameter int K  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic [idx_w(OG)-1:0]   og,
    output logic [idx_w(IG)-1:0]   ng,
    output logic [idx_w(TR)-1:0]   r,
    output logic [idx_w(TC)-1:0]   c,
    output logic [idx_w(K)-1:0]    ki,
    output logic [idx_w(K)-1:0]    kj,
    output logic                   seed,
    output logic                   finish
);
    localparam int OGW = idx_w(OG);
    localparam int IGW = idx_w(IG);
    localparam int RW  = idx_w(TR);
    localparam int CW  = idx_w(TC);
    localparam int KW  = idx_w(K);
    localparam logic [OGW-1:0] OG_LAST = OGW'(OG - 1);
    localparam logic [IGW-1:0] IG_LAST = IGW'(IG - 1);
    localparam logic [RW-1:0]  R_LAST  = RW'(TR - 1);
    localparam logic [CW-1:0]  C_LAST  = CW'(TC - 1);
    localparam logic [KW-1:0]  K_LAST  = KW'(K - 1);

    typedef struct packed {
        logic           busy;
        logic           done;
        logic [OGW-1:0] og;
        logic [IGW-1:0] ng;
        logic [RW-1:0]  r;
        logic [CW-1:0]  c;
        logic [KW-1:0]  ki;
        logic [KW-1:0]  kj;
    } sweep_t;

    sweep_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy = 1'b1;
                st_d.og   = '0;
                st_d.ng   = '0;
                st_d.r    = '0;
                st_d.c    = '0;
                st_d.ki   = '0;
                st_d.kj   = '0;
            end
        end else if (st_q.kj != K_LAST) begin
            st_d.kj = st_q.kj + 1'b1;
        end else begin
            st_d.kj = '0;
            if (st_q.ki != K_LAST) begin
                st_d.ki = st_q.ki + 1'b1;
            end else begin
                st_d.ki = '0;
                if (st_q.c != C_LAST) begin
                    st_d.c = st_q.c + 1'b1;
                end else begin
                    st_d.c = '0;
                    if (st_q.r != R_LAST) begin
                        st_d.r = st_q.r + 1'b1;
                    end else begin
                        st_d.r = '0;
                        if (st_q.ng != IG_LAST) begin
                            st_d.ng = st_q.ng + 1'b1;
                        end else begin
                            st_d.ng = '0;
                            if (st_q.og != OG_LAST) begin
                                st_d.og = st_q.og + 1'b1;
                            end else begin
                                st_d.og   = '0;
                                st_d.busy = 1'b0;
                                st_d.done = 1'b1;
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign og     = st_q.og;
    assign ng     = st_q.ng;
    assign r      = st_q.r;
    assign c      = st_q.c;
    assign ki     = st_q.ki;
    assign kj     = st_q.kj;
    assign seed   = (st_q.ng == '0) && (st_q.ki == '0) && (st_q.kj == '0);
    assign finish = (st_q.ng == IG_LAST) && (st_q.ki == K_LAST) && (st_q.kj == K_LAST);
endmodule

// File: rtl/conv_tile_lane.sv
module conv_tile_lane
    import conv_tile_pkg::*;
#(
    parameter int TN = 2,
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic [TN*DW-1:0] x_vec,
    input  logic [TN*DW-1:0] w_vec,
    input  logic [AW-1:0]    acc_old,
    input  logic [AW-1:0]    bias,
    input  logic             seed,
    input  logic             rectify,
    output logic [AW-1:0]    result
);
    localparam int PW = 2 * DW + idx_w(TN) + 1;

    logic signed [PW-1:0] dot;
    logic signed [PW-1:0] xa, wb;
    logic        [AW-1:0] base;
    logic signed [AW:0]   base_x, dot_x, sum;
    logic        [AW-1:0] clamped;

    always_comb begin
        dot = '0;
        xa  = '0;
        wb  = '0;
        for (int t = 0; t < TN; t++) begin
            xa  = PW'($signed(x_vec[t*DW +: DW]));
            wb  = PW'($signed(w_vec[t*DW +: DW]));
            dot = dot + xa * wb;
        end
    end

    always_comb begin
        base   = seed ? bias : acc_old;
        base_x = {base[AW-1], base};
        dot_x  = (AW+1)'(dot);
        sum    = base_x + dot_x;
        if (sum[AW] != sum[AW-1])
            clamped = sum[AW] ? {1'b1, {(AW-1){1'b0}}} : {1'b0, {(AW-1){1'b1}}};
        else
            clamped = sum[AW-1:0];
        result = (rectify && clamped[AW-1]) ? '0 : clamped;
    end
endmodule

// File: rtl/conv_tile_engine.sv
module conv_tile_engine
    import conv_tile_pkg::*;
#(
    parameter int TM = 2,
    parameter int TN = 2,
    parameter int TR = 3,
    parameter int TC = 3,
    parameter int K  = 3,
    parameter int S  = 2,
    parameter int OG = 2,
    parameter int IG = 2,
    parameter int DW = 8,
    parameter int AW = 20
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 start,
    output logic                                 busy,
    output logic                                 done,
    output logic [idx_w(IG)-1:0]                 in_grp,
    output logic [idx_w((TR-1)*S+K)-1:0]         in_row,
    output logic [idx_w((TC-1)*S+K)-1:0]         in_col,
    input  logic [TN*DW-1:0]                     in_data,
    output logic [idx_w(OG)-1:0]                 wt_ogrp,
    output logic [idx_w(IG)-1:0]                 wt_igrp,
    output logic [idx_w(K)-1:0]                  wt_krow,
    output logic [idx_w(K)-1:0]                  wt_kcol,
    input  logic [TM*TN*DW-1:0]                  wt_data,
    output logic [idx_w(OG)-1:0]                 bias_grp,
    input  logic [TM*AW-1:0]                     bias_data,
    output logic [idx_w(OG)-1:0]                 acc_grp,
    output logic [idx_w(TR)-1:0]                 acc_row,
    output logic [idx_w(TC)-1:0]                 acc_col,
    input  logic [TM*AW-1:0]                     acc_rd_data,
    output logic                                 acc_we,
    output logic [TM*AW-1:0]                     acc_wr_data
);
    localparam int IN_ROWS = (TR - 1) * S + K;
    localparam int IN_COLS = (TC - 1) * S + K;
    localparam int IRW = idx_w(IN_ROWS);
    localparam int ICW = idx_w(IN_COLS);
    localparam int OGW = idx_w(OG);
    localparam int IGW = idx_w(IG);
    localparam int RW  = idx_w(TR);
    localparam int CW  = idx_w(TC);
    localparam int KW  = idx_w(K);

    logic           run, fin_pulse, seed, finish;
    logic [OGW-1:0] og;
    logic [IGW-1:0] ng;
    logic [RW-1:0]  r;
    logic [CW-1:0]  c;
    logic [KW-1:0]  ki, kj;

    conv_tile_sweep #(.OG(OG), .IG(IG), .TR(TR), .TC(TC), .K(K)) u_sweep (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (run),
        .done   (fin_pulse),
        .og     (og),
        .ng     (ng),
        .r      (r),
        .c      (c),
        .ki     (ki),
        .kj     (kj),
        .seed   (seed),
        .finish (finish)
    );

    // Strided window into the input tile
    assign in_row   = IRW'(S * int'(r) + int'(ki));
    assign in_col   = ICW'(S * int'(c) + int'(kj));
    assign in_grp   = ng;
    assign wt_ogrp  = og;
    assign wt_igrp  = ng;
    assign wt_krow  = ki;
    assign wt_kcol  = kj;
    assign bias_grp = og;
    assign acc_grp  = og;
    assign acc_row  = r;
    assign acc_col  = c;
    assign acc_we   = run;
    assign busy     = run;
    assign done     = fin_pulse;

    for (genvar m = 0; m < TM; m++) begin : g_lane
        conv_tile_lane #(.TN(TN), .DW(DW), .AW(AW)) u_lane (
            .x_vec   (in_data),
            .w_vec   (wt_data[m*TN*DW +: TN*DW]),
            .acc_old (acc_rd_data[m*AW +: AW]),
            .bias    (bias_data[m*AW +: AW]),
            .seed    (seed),
            .rectify (finish),
            .result  (acc_wr_data[m*AW +: AW])
        );
    end
endmodule

// File: rtl/conv_tile_engine_chk.sv
module conv_tile_engine_chk
    import conv_tile_pkg::*;
#(
    parameter int TM = 2,
    parameter int TR = 3,
    parameter int TC = 3,
    parameter int K  = 3,
    parameter int S  = 2,
    parameter int OG = 2,
    parameter int IG = 2,
    parameter int AW = 20
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         busy,
    input logic                         done,
    input logic                         acc_we,
    input logic [idx_w(IG)-1:0]         in_grp,
    input logic [idx_w((TR-1)*S+K)-1:0] in_row,
    input logic [idx_w((TC-1)*S+K)-1:0] in_col,
    input logic [idx_w(K)-1:0]          wt_krow,
    input logic [idx_w(K)-1:0]          wt_kcol,
    input logic [idx_w(OG)-1:0]         acc_grp,
    input logic [idx_w(TR)-1:0]         acc_row,
    input logic [idx_w(TC)-1:0]         acc_col,
    input logic [TM*AW-1:0]             acc_wr_data
);
    localparam int KW = idx_w(K);
    localparam int IGW = idx_w(IG);
    localparam logic [KW-1:0]  K_LAST  = KW'(K - 1);
    localparam logic [IGW-1:0] IG_LAST = IGW'(IG - 1);
    localparam int IN_ROWS = (TR - 1) * S + K;
    localparam int IN_COLS = (TC - 1) * S + K;

    logic any_neg;
    always_comb begin
        any_neg = 1'b0;
        for (int m = 0; m < TM; m++) any_neg = any_neg | acc_wr_data[m*AW + AW - 1];
    end

    // R8: single-cycle completion pulse
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: pulse follows the run, with the run already over
    a_r8_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !acc_we && $past(busy)));
    // R10: no write outside a run
    a_r10_we_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        acc_we |-> busy);
    // R2: every run starts at the origin of all loops
    a_r2_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (acc_grp == '0 && in_grp == '0 && acc_row == '0 &&
                         acc_col == '0 && wt_krow == '0 && wt_kcol == '0));
    // R2: the kernel column is the innermost loop
    a_r2_kcol_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(wt_kcol) != K_LAST) |-> (wt_kcol == $past(wt_kcol) + 1'b1));
    // R3: window stays inside the input tile
    a_r3_window_in_tile: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(in_row) < IN_ROWS && int'(in_col) < IN_COLS));
    // R7: the final step never writes a negative value
    a_r7_final_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && in_grp == IG_LAST && wt_krow == K_LAST && wt_kcol == K_LAST) |-> !any_neg);
endmodule

bind conv_tile_engine conv_tile_engine_chk #(
    .TM(TM), .TR(TR), .TC(TC), .K(K), .S(S), .OG(OG), .IG(IG), .AW(AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .acc_we      (acc_we),
    .in_grp      (in_grp),
    .in_row      (in_row),
    .in_col      (in_col),
    .wt_krow     (wt_krow),
    .wt_kcol     (wt_kcol),
    .acc_grp     (acc_grp),
    .acc_row     (acc_row),
    .acc_col     (acc_col),
    .acc_wr_data (acc_wr_data)
);

// File: tb/conv_tile_engine_bench.sv
module conv_tile_engine_bench;
    import conv_tile_pkg::*;

    localparam int TM = 2, TN = 2, TR = 3, TC = 3, K = 3, S = 2, OG = 2, IG = 2, DW = 8, AW = 20;
    localparam int IR = (TR - 1) * S + K;
    localparam int IC = (TC - 1) * S + K;
    localparam longint SMAX = (64'sd1 <<< (AW - 1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (AW - 1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #5 clk = ~clk;

    logic busy, done, acc_we;
    logic [idx_w(IG)-1:0] in_grp, wt_igrp;
    logic [idx_w(IR)-1:0] in_row;
    logic [idx_w(IC)-1:0] in_col;
    logic [idx_w(OG)-1:0] wt_ogrp, bias_grp, acc_grp;
    logic [idx_w(K)-1:0]  wt_krow, wt_kcol;
    logic [idx_w(TR)-1:0] acc_row;
    logic [idx_w(TC)-1:0] acc_col;
    logic [TN*DW-1:0]     in_data;
    logic [TM*TN*DW-1:0]  wt_data;
    logic [TM*AW-1:0]     bias_data, acc_rd_data, acc_wr_data;

    logic signed [DW-1:0] in_mem  [IG][IR][IC][TN];
    logic signed [DW-1:0] wt_mem  [OG][IG][K][K][TM][TN];
    logic        [AW-1:0] bias_mem[OG][TM];
    logic        [AW-1:0] out_mem [OG][TR][TC][TM];
    longint               ref_mem [OG][TR][TC][TM];
    logic                 junk_req = 1'b0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    conv_tile_engine #(.TM(TM), .TN(TN), .TR(TR), .TC(TC), .K(K), .S(S),
                       .OG(OG), .IG(IG), .DW(DW), .AW(AW)) u_conv_tile_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .in_grp(in_grp), .in_row(in_row), .in_col(in_col), .in_data(in_data),
        .wt_ogrp(wt_ogrp), .wt_igrp(wt_igrp), .wt_krow(wt_krow), .wt_kcol(wt_kcol),
        .wt_data(wt_data), .bias_grp(bias_grp), .bias_data(bias_data),
        .acc_grp(acc_grp), .acc_row(acc_row), .acc_col(acc_col),
        .acc_rd_data(acc_rd_data), .acc_we(acc_we), .acc_wr_data(acc_wr_data)
    );

    // Memory models with asynchronous read
    always_comb begin
        for (int t = 0; t < TN; t++) in_data[t*DW +: DW] = in_mem[in_grp][in_row][in_col][t];
        for (int m = 0; m < TM; m++) begin
            for (int t = 0; t < TN; t++)
                wt_data[(m*TN+t)*DW +: DW] = wt_mem[wt_ogrp][wt_igrp][wt_krow][wt_kcol][m][t];
            bias_data[m*AW +: AW]   = bias_mem[bias_grp][m];
            acc_rd_data[m*AW +: AW] = out_mem[acc_grp][acc_row][acc_col][m];
        end
    end

    always @(posedge clk) begin
        if (junk_req) begin
            for (int g = 0; g < OG; g++)
                for (int r = 0; r < TR; r++)
                    for (int c = 0; c < TC; c++)
                        for (int m = 0; m < TM; m++)
                            out_mem[g][r][c][m] <= AW'(32'h5A5A5 + g*97 + r*13 + c*7 + m);
        end else if (acc_we) begin
            for (int m = 0; m < TM; m++)
                out_mem[acc_grp][acc_row][acc_col][m] <= acc_wr_data[m*AW +: AW];
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint sat(input longint v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom_range(0, hi - lo));
    endfunction

    // mode 0 small random, 1 full random, 2 positive overflow, 3 negative overflow, 4 negative bias
    task automatic load(input int mode);
        for (int g = 0; g < IG; g++)
            for (int r = 0; r < IR; r++)
                for (int c = 0; c < IC; c++)
                    for (int t = 0; t < TN; t++)
                        case (mode)
                            0: in_mem[g][r][c][t] = DW'(rnd(-8, 7));
                            1: in_mem[g][r][c][t] = DW'(rnd(-128, 127));
                            2, 3: in_mem[g][r][c][t] = 8'sd127;
                            default: in_mem[g][r][c][t] = DW'(rnd(0, 3));
                        endcase
        for (int o = 0; o < OG; o++)
            for (int g = 0; g < IG; g++)
                for (int i = 0; i < K; i++)
                    for (int j = 0; j < K; j++)
                        for (int m = 0; m < TM; m++)
                            for (int t = 0; t < TN; t++)
                                case (mode)
                                    0: wt_mem[o][g][i][j][m][t] = DW'(rnd(-8, 7));
                                    1: wt_mem[o][g][i][j][m][t] = DW'(rnd(-128, 127));
                                    2: wt_mem[o][g][i][j][m][t] = 8'sd127;
                                    3: wt_mem[o][g][i][j][m][t] = -8'sd128;
                                    default: wt_mem[o][g][i][j][m][t] = DW'(rnd(0, 3));
                                endcase
        for (int o = 0; o < OG; o++)
            for (int m = 0; m < TM; m++)
                case (mode)
                    0: bias_mem[o][m] = AW'(rnd(-100, 100));
                    1: bias_mem[o][m] = AW'(rnd(-20000, 20000));
                    2: bias_mem[o][m] = AW'(SMAX - 10);
                    3: bias_mem[o][m] = '0;
                    default: bias_mem[o][m] = AW'(-100000);
                endcase
        @(negedge clk) junk_req = 1'b1;
        @(negedge clk) junk_req = 1'b0;
    endtask

    // Runs one tile; the bench's own loop nest is the expected step sequence
    task automatic run_tile(input string name, input bit stray_start);
        int step = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        for (int o = 0; o < OG; o++)
          for (int g = 0; g < IG; g++)
            for (int r = 0; r < TR; r++)
              for (int c = 0; c < TC; c++)
                for (int i = 0; i < K; i++)
                  for (int j = 0; j < K; j++) begin
                    bit seed_s = (g == 0 && i == 0 && j == 0);
                    bit last_s = (g == IG-1 && i == K-1 && j == K-1);
                    bit addr_ok;
                    // R2 order, R3 addressing, R10 write strobe in every step
                    addr_ok = busy && acc_we && !done &&
                              int'(in_grp) == g && int'(in_row) == S*r+i && int'(in_col) == S*c+j &&
                              int'(wt_ogrp) == o && int'(wt_igrp) == g && int'(wt_krow) == i &&
                              int'(wt_kcol) == j && int'(bias_grp) == o &&
                              int'(acc_grp) == o && int'(acc_row) == r && int'(acc_col) == c;
                    check(addr_ok, {"R2/R3/R10 step address ", name}, step, step);
                    for (int m = 0; m < TM; m++) begin
                        longint old, dot, raw, expv, act;
                        string tag;
                        old = seed_s ? longint'($signed(bias_mem[o][m])) : ref_mem[o][r][c][m];
                        dot = 0;
                        for (int t = 0; t < TN; t++)
                            dot += longint'(in_mem[g][S*r+i][S*c+j][t]) * longint'(wt_mem[o][g][i][j][m][t]);
                        raw  = old + dot;
                        expv = sat(raw);
                        if (last_s && expv < 0) expv = 0;
                        ref_mem[o][r][c][m] = expv;
                        act = longint'($signed(acc_wr_data[m*AW +: AW]));
                        if (raw != sat(raw))          tag = "R6 saturate";
                        else if (last_s)              tag = "R7 rectify final";
                        else if (seed_s)              tag = "R5 bias seed";
                        else if (expv < 0)            tag = "R7 negative partial kept";
                        else                          tag = "R4 lane sum";
                        check(act == expv, {tag, " ", name}, act, expv);
                    end
                    // R9: a stray start inside the run must not disturb it
                    start = (stray_start && step == 7) ? 1'b1 : 1'b0;
                    step++;
                    @(negedge clk);
                  end
        start = 1'b0;
        // R8: completion pulse after the final write
        check(done && !busy && !acc_we, {"R8 done pulse ", name}, longint'(done), 1);
        @(negedge clk);
        check(!done && !busy, {"R8 done one cycle ", name}, longint'(done), 0);
        // R4: final memory image
        for (int o = 0; o < OG; o++)
            for (int r = 0; r < TR; r++)
                for (int c = 0; c < TC; c++)
                    for (int m = 0; m < TM; m++)
                        check(longint'($signed(out_mem[o][r][c][m])) == ref_mem[o][r][c][m],
                              {"R4 final image ", name},
                              longint'($signed(out_mem[o][r][c][m])), ref_mem[o][r][c][m]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!busy && !done && !acc_we, "R1 reset state", longint'({busy, done, acc_we}), 0);
        rst_n = 1'b1;
        // R10: idle, no writes
        repeat (3) begin
            @(negedge clk);
            check(!acc_we && !busy && !done, "R10 idle quiet", longint'(acc_we), 0);
        end
        load(0); run_tile("small random", 1'b1);
        load(1); run_tile("full random", 1'b0);
        load(2); run_tile("positive overflow", 1'b0);
        load(3); run_tile("negative overflow", 1'b1);
        load(4); run_tile("negative bias", 1'b0);
        // back-to-back restart without refilling: old sums replaced by bias seed (R5)
        run_tile("restart", 1'b0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule